// File: doc/BRIEF.md
# Eight-Channel Serial ADC Scan Controller

This block is the host-side master for an external eight-input, 12-bit serial converter. It uses a four-wire link: an active-low select, a serial clock, a command line to the converter and a data line from it. It also watches a strobe line that the converter drives.

A single `start` pulse launches a scan of all eight inputs in ascending channel order. Each frame has three phases:

- **Command.** The block lowers select and sends an 8-bit command byte.
- **Wait.** It then stops the serial clock until the strobe falls. The strobe is synchronised with two flops before its falling edge is detected.
- **Read.** It clocks sixteen bits back. It keeps the first twelve as the conversion code, drops the last four, and raises select again.

Each result comes out on a simple result port, together with its channel number and a flag that marks the code as two's complement. The flag is set when the scan was launched in bipolar mode.

If the strobe never falls, a timeout counter aborts the frame and raises a sticky error flag. The scan then moves on to the next channel. The serial clock rate is a parameter: the number of system clocks in each half period of the serial clock.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is high and after it is released, `adc_cs_n` is 1, and `adc_sclk`, `busy`, `res_valid` and `scan_err` are 0.
- R2: `adc_sclk` is 0 whenever `adc_cs_n` is 1. Each high phase of `adc_sclk` lasts exactly HALF_DIV system clocks. `adc_din` is meant to be sampled on the rising edge of `adc_sclk`.
- R3: Each frame begins with an 8-bit command byte sent MSB first on `adc_din`. Bit 7 is 1. Bits 6..4 hold the channel. Bit 3 is 1 for bipolar. Bit 2 is 1 for differential. Bits 1..0 are 11.
- R4: After the command byte, `adc_sclk` stays low until a falling edge of the synchronised `adc_strb`. Exactly 16 rising edges of `adc_sclk` follow, so a completed frame has 24 rising edges in total.
- R5: The read bits arrive MSB first on `adc_dout`. `res_data` holds the first 12 of them, and the last 4 do not affect it.
- R6: `adc_cs_n` rises together with the last falling edge of `adc_sclk`. It stays high for at least GAP_CYCLES system clocks before the next frame begins.
- R7: One scan covers channels 0 to 7 in ascending order. Each completed frame gives one `res_valid` pulse, and `res_chan` equals the channel named in that frame's command byte.
- R8: `res_signed` equals the bipolar setting. The mode inputs are sampled when the scan starts and hold for all eight frames.
- R9: If no strobe fall arrives within TIMEOUT_CYCLES clocks of the end of the command byte, the frame is aborted:
  - `adc_cs_n` rises after 8 rising edges of `adc_sclk`;
  - no result is given for that channel;
  - `scan_err` is set;
  - the scan continues with the next channel.
  `scan_err` stays set until the next accepted start.
- R10: `busy` rises in the clock after an accepted start. It falls after the eighth frame ends, and `res_valid` is only ever high while `busy` is high.
- R11: A `start` pulse while `busy` is high is ignored. The scan in progress runs to its eight frames unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one eight-channel scan when idle |
| cfg_bipolar | input | 1 | Bipolar mode request, sampled at start |
| cfg_diff | input | 1 | Differential input request, sampled at start |
| adc_dout | input | 1 | Serial data from the converter |
| adc_strb | input | 1 | Converter strobe, asynchronous |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_din | output | 1 | Serial command data to the converter |
| busy | output | 1 | High while a scan is running |
| scan_err | output | 1 | Sticky strobe timeout flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel of the presented result |
| res_data | output | 12 | Conversion code |
| res_signed | output | 1 | Code is two's complement |

## Verification
The assertions take three things for granted:
- `start` and the mode inputs are synchronous to `clk`;
- the strobe may change at any time but is only acted on during the wait phase;
- the converter changes `adc_dout` on the falling edge of the serial clock, so the data is stable when the controller samples it.

The bench's converter model meets these conditions. It drives the strobe and the mode inputs only on the falling edge of `clk`, and it raises and lowers the strobe only after it has seen the full command byte. It updates `adc_dout` only on falling serial clock edges.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CHAN_W   = 3;
    localparam int NUM_CHAN = 8;
    localparam int RES_W    = 12;
    localparam int CTRL_W   = 8;
    localparam int FRAME_W  = 16;
    localparam int BC_W     = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX,
        ST_GAP
    } frame_state_t;

    typedef struct packed {
        logic bipolar;
        logic diff;
    } scan_cfg_t;

    // Command byte: start bit, channel, mode bits, external-clock normal operation.
    function automatic logic [CTRL_W-1:0] make_ctrl(input logic [CHAN_W-1:0] ch,
                                                    input scan_cfg_t cfg);
        return {1'b1, ch, cfg.bipolar, cfg.diff, 2'b11};
    endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;

            assign tick = run && (cnt == CW'(HALF_DIV - 1));

            always_ff @(posedge clk) begin
                if (rst || !run || tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end

            // R2: half periods never shorter than one divider round
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/adc_strb_sync.sv
module adc_strb_sync (
    input  logic clk,
    input  logic rst,
    input  logic strb_async,
    output logic strb_fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= strb_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign strb_fall = prev_q & ~sync_q;

    // R4: one detected edge per strobe fall
    a_r4_single_fall: assert property (@(posedge clk) disable iff (rst)
        strb_fall |=> !strb_fall);
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV       = 2,
    parameter int TIMEOUT_CYCLES = 256,
    parameter int GAP_CYCLES     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [CTRL_W-1:0] ctrl_byte,
    input  logic              dout_in,
    input  logic              strb_fall,
    output logic              cs_n,
    output logic              sclk,
    output logic              din,
    output logic              res_ok,
    output logic [RES_W-1:0]  res_code,
    output logic              tmo_pulse,
    output logic              frame_done
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    frame_state_t      state;
    logic [BC_W-1:0]   bitcnt;
    logic [CTRL_W-1:0] tx_sh;
    logic [RES_W-1:0]  rx_sh;
    logic [TMO_W-1:0]  tmo_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              run;
    logic              tick;

    assign run = (state == ST_TX) || (state == ST_RX);
    assign din = tx_sh[CTRL_W-1];

    adc_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cs_n       <= 1'b1;
            sclk       <= 1'b0;
            bitcnt     <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            tmo_cnt    <= '0;
            gap_cnt    <= '0;
            res_ok     <= 1'b0;
            res_code   <= '0;
            tmo_pulse  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            res_ok     <= 1'b0;
            tmo_pulse  <= 1'b0;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        cs_n   <= 1'b0;
                        tx_sh  <= ctrl_byte;
                        bitcnt <= '0;
                        state  <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bitcnt == BC_W'(CTRL_W - 1)) begin
                                tx_sh   <= '0;
                                tmo_cnt <= '0;
                                state   <= ST_WAIT;
                            end else begin
                                bitcnt <= bitcnt + BC_W'(1);
                                tx_sh  <= {tx_sh[CTRL_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (strb_fall) begin
                        bitcnt <= '0;
                        state  <= ST_RX;
                    end else if (tmo_cnt == TMO_W'(TIMEOUT_CYCLES - 1)) begin
                        cs_n      <= 1'b1;
                        tmo_pulse <= 1'b1;
                        gap_cnt   <= '0;
                        state     <= ST_GAP;
                    end else begin
                        tmo_cnt <= tmo_cnt + TMO_W'(1);
                    end
                end
                ST_RX: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                            if (bitcnt < BC_W'(RES_W)) begin
                                rx_sh <= {rx_sh[RES_W-2:0], dout_in};
                            end
                        end else begin
                            sclk <= 1'b0;
                            if (bitcnt == BC_W'(FRAME_W - 1)) begin
                                cs_n     <= 1'b1;
                                res_ok   <= 1'b1;
                                res_code <= rx_sh;
                                gap_cnt  <= '0;
                                state    <= ST_GAP;
                            end else begin
                                bitcnt <= bitcnt + BC_W'(1);
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) begin
                        frame_done <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: clock parked while waiting for the converter
    a_r4_quiet_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !sclk);

    // R6: select held low through every active phase
    a_r6_cs_in_frame: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX || state == ST_WAIT || state == ST_RX) |-> !cs_n);

    // R5: a result only follows a completed read phase
    a_r5_result_after_read: assert property (@(posedge clk) disable iff (rst)
        res_ok |-> ($past(state) == ST_RX && cs_n));

    // R9: an abort releases select and gives no result
    a_r9_abort_release: assert property (@(posedge clk) disable iff (rst)
        tmo_pulse |-> (cs_n && !res_ok));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV       = 2,
    parameter int TIMEOUT_CYCLES = 256,
    parameter int GAP_CYCLES     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_bipolar,
    input  logic              cfg_diff,
    input  logic              adc_dout,
    input  logic              adc_strb,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_din,
    output logic              busy,
    output logic              scan_err,
    output logic              res_valid,
    output logic [CHAN_W-1:0] res_chan,
    output logic [RES_W-1:0]  res_data,
    output logic              res_signed
);
    scan_cfg_t         cfg_q;
    logic [CHAN_W-1:0] chan_q;
    logic              launch_q;
    logic              strb_fall;
    logic              eng_ok;
    logic [RES_W-1:0]  eng_code;
    logic              eng_tmo;
    logic              eng_done;
    logic              accept;

    assign accept = start && !busy;

    adc_strb_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .strb_async (adc_strb),
        .strb_fall  (strb_fall)
    );

    adc_frame_engine #(
        .HALF_DIV       (HALF_DIV),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .GAP_CYCLES     (GAP_CYCLES)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch_q),
        .ctrl_byte  (make_ctrl(chan_q, cfg_q)),
        .dout_in    (adc_dout),
        .strb_fall  (strb_fall),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .din        (adc_din),
        .res_ok     (eng_ok),
        .res_code   (eng_code),
        .tmo_pulse  (eng_tmo),
        .frame_done (eng_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            chan_q     <= '0;
            launch_q   <= 1'b0;
            busy       <= 1'b0;
            scan_err   <= 1'b0;
            res_valid  <= 1'b0;
            res_chan   <= '0;
            res_data   <= '0;
            res_signed <= 1'b0;
        end else begin
            launch_q  <= 1'b0;
            res_valid <= eng_ok;
            if (eng_ok) begin
                res_data   <= eng_code;
                res_chan   <= chan_q;
                res_signed <= cfg_q.bipolar;
            end
            if (eng_tmo) begin
                scan_err <= 1'b1;
            end
            if (accept) begin
                busy     <= 1'b1;
                chan_q   <= '0;
                cfg_q    <= '{bipolar: cfg_bipolar, diff: cfg_diff};
                scan_err <= 1'b0;
                launch_q <= 1'b1;
            end else if (busy && eng_done) begin
                if (chan_q == CHAN_W'(NUM_CHAN - 1)) begin
                    busy <= 1'b0;
                end else begin
                    chan_q   <= chan_q + CHAN_W'(1);
                    launch_q <= 1'b1;
                end
            end
        end
    end

    // R2: serial clock parked low while deselected
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_sclk);

    // R10: results only appear inside a scan
    a_r10_valid_in_scan: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);

    // R9: error flag only cleared by an accepted start
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (scan_err && !accept) |=> scan_err);

    // R7: channel only moves at a frame boundary
    a_r7_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> $stable(chan_q));

    // R11: running scan keeps its configuration
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int TIMEOUT    = 256;
    localparam int GAP        = 4;
    localparam int NVEC       = 6;

    // {bipolar, diff, seed[11:0], skipped channel (8 = none)}
    localparam logic [17:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 12'h000, 4'd8},
        {1'b1, 1'b0, 12'h800, 4'd8},
        {1'b0, 1'b1, 12'hFFF, 4'd8},
        {1'b1, 1'b1, 12'h5A5, 4'd3},
        {1'b0, 1'b0, 12'h7FF, 4'd0},
        {1'b1, 1'b0, 12'h3C3, 4'd7}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, cfg_bipolar = 1'b0, cfg_diff = 1'b0;
    logic adc_dout = 1'b0, adc_strb = 1'b0;
    logic adc_cs_n, adc_sclk, adc_din, busy, scan_err, res_valid, res_signed;
    logic [2:0]  res_chan;
    logic [11:0] res_data;

    int n_checks = 0, n_errors = 0;
    int model_frame = 0, model_skip = 8, rise_cnt = 0;
    logic model_bip = 1'b0, model_diff = 1'b0;
    logic [11:0] model_seed = '0;
    logic monitor_en = 1'b0;
    time t_rise = 0, t_cs_hi = 0;
    int got_cnt = 0;
    logic [2:0]  got_chan [16];
    logic [11:0] got_data [16];
    logic        got_sgn  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_ctrl #(.HALF_DIV(HALF_DIV), .TIMEOUT_CYCLES(TIMEOUT), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_bipolar(cfg_bipolar), .cfg_diff(cfg_diff),
        .adc_dout(adc_dout), .adc_strb(adc_strb), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_din(adc_din), .busy(busy), .scan_err(scan_err), .res_valid(res_valid),
        .res_chan(res_chan), .res_data(res_data), .res_signed(res_signed)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] code_for(input logic [11:0] seed, input int ch);
        logic [2:0] c = ch[2:0];
        return seed ^ {c, c, c, c};
    endfunction

    // Converter model
    always @(posedge adc_sclk) rise_cnt++;

    initial begin
        forever begin
            logic [7:0]  ctrl;
            logic [15:0] word;
            @(negedge adc_cs_n);
            rise_cnt = 0;
            ctrl = '0;
            for (int i = 0; i < 8; i++) begin
                @(posedge adc_sclk);
                ctrl = {ctrl[6:0], adc_din};
            end
            // R3: command byte layout
            check(ctrl == {1'b1, model_frame[2:0], model_bip, model_diff, 2'b11}, "R3",
                  ctrl, {1'b1, model_frame[2:0], model_bip, model_diff, 2'b11});
            @(negedge adc_sclk);
            if (model_frame != model_skip) begin
                word = {code_for(model_seed, model_frame), 4'b1011};
                repeat (3) @(negedge clk);
                adc_strb = 1'b1;
                repeat (3) @(negedge clk);
                adc_strb = 1'b0;
                adc_dout = word[15];
                for (int i = 14; i >= 0; i--) begin
                    @(negedge adc_sclk);
                    adc_dout = word[i];
                end
            end
            @(posedge adc_cs_n);
            // R4 (and R9 for an aborted frame): rising edge count per frame
            check(rise_cnt == ((model_frame == model_skip) ? 8 : 24),
                  (model_frame == model_skip) ? "R9" : "R4", rise_cnt,
                  (model_frame == model_skip) ? 8 : 24);
            adc_dout = 1'b0;
            model_frame++;
        end
    end

    // R2: high phase width
    always @(posedge adc_sclk) t_rise = $time;
    always @(negedge adc_sclk) begin
        if (monitor_en && t_rise > 0)
            check(($time - t_rise) == HALF_DIV * CLK_PERIOD, "R2", $time - t_rise,
                  HALF_DIV * CLK_PERIOD);
    end

    // R6: deselect gap between frames
    always @(posedge adc_cs_n) if (monitor_en) t_cs_hi = $time;
    always @(negedge adc_cs_n) begin
        if (monitor_en && t_cs_hi > 0)
            check(($time - t_cs_hi) >= GAP * CLK_PERIOD, "R6", $time - t_cs_hi, GAP * CLK_PERIOD);
    end

    // Result capture
    always @(negedge clk) begin
        if (res_valid && got_cnt < 16) begin
            got_chan[got_cnt] = res_chan;
            got_data[got_cnt] = res_data;
            got_sgn[got_cnt]  = res_signed;
            got_cnt++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic run_scan(input logic bip, input logic diff, input logic [11:0] seed,
                            input int skip, input bit disturb);
        int idx;
        model_bip = bip; model_diff = diff; model_seed = seed; model_skip = skip;
        model_frame = 0; got_cnt = 0;
        @(negedge clk);
        cfg_bipolar = bip; cfg_diff = diff; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", busy, 1);
        check(scan_err == 1'b0, "R9", scan_err, 0);
        if (disturb) begin
            repeat (150) @(negedge clk);
            // R11/R8: start and mode changes during a scan are ignored
            cfg_bipolar = ~bip; cfg_diff = ~diff; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(got_cnt == ((skip < 8) ? 7 : 8), "R7", got_cnt, (skip < 8) ? 7 : 8);
        idx = 0;
        for (int ch = 0; ch < 8; ch++) begin
            if (ch != skip && idx < got_cnt) begin
                check(got_chan[idx] == ch[2:0], "R7", got_chan[idx], ch);
                check(got_data[idx] == code_for(seed, ch), "R5", got_data[idx], code_for(seed, ch));
                check(got_sgn[idx] == bip, "R8", got_sgn[idx], bip);
                idx++;
            end
        end
        check(scan_err == (skip < 8), "R9", scan_err, skip < 8);
        check(model_frame == 8, "R11", model_frame, 8);
        check(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R2", {adc_cs_n, adc_sclk}, 2'b10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1", {adc_cs_n, adc_sclk}, 2'b10);
        check(busy == 1'b0 && res_valid == 1'b0 && scan_err == 1'b0, "R1",
              {busy, res_valid, scan_err}, 3'b000);
        rst = 1'b0;
        monitor_en = 1'b1;
        @(negedge clk);
        check(adc_cs_n == 1'b1 && busy == 1'b0 && scan_err == 1'b0, "R1",
              {adc_cs_n, busy, scan_err}, 3'b100);

        for (int v = 0; v < NVEC; v++) begin
            run_scan(VECS[v][17], VECS[v][16], VECS[v][15:4], int'(VECS[v][3:0]), 1'b0);
        end

        // R11: mid-scan start with flipped modes
        run_scan(1'b1, 1'b0, 12'hA5A, 8, 1'b1);
        // R9: error cleared by a clean scan after an aborted one
        run_scan(1'b0, 1'b1, 12'h123, 5, 1'b0);
        run_scan(1'b0, 1'b0, 12'h456, 8, 1'b0);

        repeat (5) @(negedge clk);
        check(busy == 1'b0 && res_valid == 1'b0, "R10", {busy, res_valid}, 2'b00);
        finish_run();
    end
endmodule